// File: doc/BRIEF.md
# GPIO Port with Change Interrupt

An 8-bit general-purpose I/O port controlled through a small register bus. Each bit has a direction setting and an output latch. The block drives per-pin output-enable, output-value and pull-up-enable signals to the pad ring. It receives raw pin levels and passes them through a two-stage synchronizer before using them.

The upper four bits can raise a change interrupt. Each of these bits that is set as an input is compared with a copy of its value taken at the last access to the data register. Any difference sets a sticky flag, and that flag also drives a wake request. Bit 0 can also act as an external interrupt input. It responds to either the rising or the falling edge, chosen by software.

Software clears the change interrupt in two steps. First it reads or writes the data register, which refreshes the copy and ends the mismatch. Then it writes 0 to the flag.

Top module: `gpio_chg_port`

## Requirements
- R1: `pin_oe[i]` is the inverse of direction bit i (address 1; 1 = input, 0 = output). `pin_out` always equals the output latch. Reset sets every direction bit to 1 and clears the latch.
- R2: A read of the data register (address 0) returns the synchronized pin level for input bits and the latch value for output bits. A pin change appears there on the second clock edge.
- R3: A write to the data register updates the output latch whatever the direction bits hold.
- R4: Control register (address 2) bit 0 is an active-low pull-up enable. `pin_pu[i]` is 1 only when that bit is 0 and bit i is an input. Reset sets the bit to 1, so all pull-ups are off.
- R5: When a bit of [7:4] is an input and its synchronized level differs from the stored copy, flag register (address 3) bit 0 is set. `irq_chg` shows this flag, no later than the third clock edge after the pin changes. Bits [3:0] never set this flag.
- R6: Bits of [7:4] that are set as outputs are left out of the change comparison.
- R7: Any read or write of the data register reloads the stored copy from the synchronized pins. While a mismatch exists, the change flag is set again even when 0 is written to it. After the copy is refreshed, writing 0 clears the flag.
- R8: `wake_req` is asserted whenever the change flag is set.
- R9: Control bit 1 selects the bit-0 edge (1 = rising, 0 = falling). The selected edge on the synchronized bit 0 sets flag bit 1 (`irq_ext`). The other edge is ignored.
- R10: Both flags are sticky. A flag changes only through a bus write of the flag register or through its own set condition. Reset clears both flags and the stored copy, and sets control to 0x03.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| pin_in | input | 8 | Raw pin levels |
| pin_oe | output | 8 | Per-pin output enable |
| pin_out | output | 8 | Per-pin output value |
| pin_pu | output | 8 | Per-pin weak pull-up enable |
| irq_chg | output | 1 | Change-interrupt flag |
| irq_ext | output | 1 | Bit-0 edge-interrupt flag |
| wake_req | output | 1 | Wake-from-sleep request |

## Verification
The assertions assume that reset is held from time zero and that `bus_rd` and `bus_wr` are never high in the same cycle. They treat a flag-register write with a data bit of 0 as the only way a flag may fall. The bench makes at most one bus access per cycle and drives pins and strobes only on the falling edge. Before it checks a flag or reads data, it holds the pins steady for at least four cycles, so the synchronizer has settled.

// File: rtl/gpio_chg_pkg.sv
package gpio_chg_pkg;

    localparam int PORT_W = 8;
    localparam int CHG_LO = 4;

    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_FLAG = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic edge_rise;
        logic pull_n;
    } ctrl_t;

    typedef struct packed {
        logic ext;
        logic chg;
    } flag_t;

    localparam ctrl_t CTRL_RST = '{edge_rise: 1'b1, pull_n: 1'b1};

    function automatic logic [PORT_W-1:0] port_view(
        input logic [PORT_W-1:0] dir,
        input logic [PORT_W-1:0] lat,
        input logic [PORT_W-1:0] pin
    );
        return (dir & pin) | (~dir & lat);
    endfunction

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
            q    <= '0;
        end else begin
            s1_q <= d;
            q    <= s1_q;
        end
    end
endmodule

// File: rtl/gpio_chg_detect.sv
module gpio_chg_detect #(
    parameter int W  = 8,
    parameter int LO = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_s,
    input  logic [W-1:0] dir,
    input  logic         refresh,
    output logic         mismatch
);
    localparam int NB = W - LO;

    logic [NB-1:0] snap_q;
    logic [NB-1:0] diff;

    always_ff @(posedge clk) begin
        if (rst)          snap_q <= '0;
        else if (refresh) snap_q <= pin_s[W-1:LO];
    end

    for (genvar i = 0; i < NB; i++) begin : g_cmp
        assign diff[i] = dir[LO+i] & (pin_s[LO+i] ^ snap_q[i]);
    end

    assign mismatch = |diff;
endmodule

// File: rtl/gpio_ext_edge.sv
module gpio_ext_edge (
    input  logic clk,
    input  logic rst,
    input  logic pin_s,
    input  logic rise_sel,
    output logic hit
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= pin_s;
    end

    assign hit = rise_sel ? (pin_s & ~prev_q) : (~pin_s & prev_q);
endmodule

// File: rtl/gpio_chg_port.sv
module gpio_chg_port
    import gpio_chg_pkg::*;
#(
    parameter int W  = PORT_W,
    parameter int LO = CHG_LO
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   bus_addr,
    input  logic         bus_wr,
    input  logic         bus_rd,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_pu,
    output logic         irq_chg,
    output logic         irq_ext,
    output logic         wake_req
);
    reg_sel_e     sel;
    logic [W-1:0] pin_s;
    logic [W-1:0] dir_q;
    logic [W-1:0] lat_q;
    ctrl_t        ctrl_q;
    flag_t        flag_q;
    flag_t        flag_d;
    logic         chg_mismatch;
    logic         ext_hit;
    logic         port_touch;

    assign sel        = reg_sel_e'(bus_addr);
    assign port_touch = (bus_rd | bus_wr) && (sel == SEL_DATA);

    gpio_sync2 #(.W(W)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pin_s)
    );

    gpio_chg_detect #(.W(W), .LO(LO)) u_chg (
        .clk      (clk),
        .rst      (rst),
        .pin_s    (pin_s),
        .dir      (dir_q),
        .refresh  (port_touch),
        .mismatch (chg_mismatch)
    );

    gpio_ext_edge u_ext (
        .clk      (clk),
        .rst      (rst),
        .pin_s    (pin_s[0]),
        .rise_sel (ctrl_q.edge_rise),
        .hit      (ext_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q  <= '1;
            lat_q  <= '0;
            ctrl_q <= CTRL_RST;
        end else if (bus_wr) begin
            case (sel)
                SEL_DATA: lat_q  <= bus_wdata;
                SEL_DIR:  dir_q  <= bus_wdata;
                SEL_CTRL: ctrl_q <= ctrl_t'(bus_wdata[1:0]);
                default:  ;
            endcase
        end
    end

    always_comb begin
        flag_d = flag_q;
        if (bus_wr && sel == SEL_FLAG) flag_d = flag_t'(bus_wdata[1:0]);
        if (chg_mismatch) flag_d.chg = 1'b1;
        if (ext_hit)      flag_d.ext = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) flag_q <= '0;
        else     flag_q <= flag_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_DATA: bus_rdata = port_view(dir_q, lat_q, pin_s);
            SEL_DIR:  bus_rdata = dir_q;
            SEL_CTRL: bus_rdata[1:0] = ctrl_q;
            SEL_FLAG: bus_rdata[1:0] = flag_q;
            default:  bus_rdata = '0;
        endcase
    end

    assign pin_oe   = ~dir_q;
    assign pin_out  = lat_q;
    assign pin_pu   = dir_q & {W{~ctrl_q.pull_n}};
    assign irq_chg  = flag_q.chg;
    assign irq_ext  = flag_q.ext;
    assign wake_req = flag_q.chg;
endmodule

// File: rtl/gpio_chg_port_chk.sv
module gpio_chg_port_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] pin_oe,
    input logic [W-1:0] pin_pu,
    input logic         irq_chg,
    input logic         irq_ext,
    input logic         mismatch,
    input logic         edge_hit,
    input logic         bus_wr,
    input logic [1:0]   bus_addr,
    input logic [W-1:0] bus_wdata
);
    logic clr_chg;
    logic clr_ext;

    assign clr_chg = bus_wr && bus_addr == 2'd3 && !bus_wdata[0];
    assign clr_ext = bus_wr && bus_addr == 2'd3 && !bus_wdata[1];

    // R4
    pull_vs_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (pin_pu & pin_oe) == '0);

    // R7
    mismatch_reset_chk: assert property (@(posedge clk) disable iff (rst)
        mismatch |=> irq_chg);

    // R10
    chg_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_chg && !clr_chg) |=> irq_chg);

    // R10
    ext_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_ext && !clr_ext) |=> irq_ext);

    // R9
    ext_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_ext) |-> $past(edge_hit));

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pin_oe == '0 && pin_pu == '0 && !irq_chg && !irq_ext));
endmodule

bind gpio_chg_port gpio_chg_port_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pin_oe    (pin_oe),
    .pin_pu    (pin_pu),
    .irq_chg   (irq_chg),
    .irq_ext   (irq_ext),
    .mismatch  (chg_mismatch),
    .edge_hit  (ext_hit),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata)
);

// File: tb/test_gpio_chg_port.sv
module test_gpio_chg_port;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] pin_oe, pin_out, pin_pu;
    logic       irq_chg, irq_ext, wake_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gpio_chg_port i_gpio_chg_port (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out), .pin_pu(pin_pu),
        .irq_chg(irq_chg), .irq_ext(irq_ext), .wake_req(wake_req)
    );

    function automatic logic [7:0] exp_read(logic [7:0] dir, logic [7:0] lat, logic [7:0] pins);
        return (dir & pins) | (~dir & lat);
    endfunction

    function automatic logic [7:0] exp_pull(logic [7:0] dir, logic pull_n);
        return pull_n ? 8'h00 : dir;
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, string req, logic [7:0] exp);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 check(req, bus_rdata, exp);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] dir_m, lat_m, pins_m;
        logic       pull_m;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 R4 R10 reset state
        check("R1 oe", pin_oe, 8'h00);
        check("R1 out", pin_out, 8'h00);
        check("R4 pu", pin_pu, 8'h00);
        check("R10 flags", {irq_ext, irq_chg, wake_req}, 8'h00);
        rd(2'd1, "R1 dir", 8'hFF);
        rd(2'd2, "R10 ctrl", 8'h03);
        rd(2'd3, "R10 flagreg", 8'h00);
        rd(2'd0, "R2 data", 8'h00);

        // R3 write with all inputs, then turn to outputs
        wr(2'd0, 8'hA5);
        check("R3 latch", pin_out, 8'hA5);
        wr(2'd1, 8'h0F);
        check("R1 oe", pin_oe, 8'hF0);
        pin_in = 8'h3C; settle();
        rd(2'd0, "R2 mixed", 8'hAC);

        // R6 outputs ignored in change compare; R5 lower bits ignored
        wr(2'd3, 8'h00);
        pin_in = 8'hC6; settle();
        check("R6 masked", {7'd0, irq_chg}, 8'h00);
        check("R5 lower", {7'd0, irq_chg}, 8'h00);
        // restore upper pins to snapshot (3) then back to inputs
        pin_in = 8'h30; settle();
        wr(2'd1, 8'hFF);
        settle();
        check("R5 quiet", {7'd0, irq_chg}, 8'h00);
        rd(2'd0, "R2 in", 8'h30);

        // R5 R8 R7 change detect and clear sequence
        pin_in = 8'h10; settle();
        check("R5 set", {7'd0, irq_chg}, 8'h01);
        check("R8 wake", {7'd0, wake_req}, 8'h01);
        wr(2'd3, 8'h00);
        check("R7 reassert", {7'd0, irq_chg}, 8'h01);
        rd(2'd0, "R7 read", 8'h10);
        wr(2'd3, 8'h00);
        check("R7 cleared", {7'd0, irq_chg}, 8'h00);
        check("R8 wake off", {7'd0, wake_req}, 8'h00);

        // R7 a data write also refreshes the copy
        pin_in = 8'h50; settle();
        check("R5 bit6", {7'd0, irq_chg}, 8'h01);
        wr(2'd0, 8'h00);
        wr(2'd3, 8'h00);
        check("R7 write refresh", {7'd0, irq_chg}, 8'h00);

        // R4 pull-ups on with mixed direction
        wr(2'd2, 8'h02);
        wr(2'd1, 8'h96);
        check("R4 mixed", pin_pu, 8'h96);
        wr(2'd1, 8'hFF);

        // R9 edge select
        pin_in = 8'h51; settle();
        check("R9 rise", {7'd0, irq_ext}, 8'h01);
        check("R10 chg idle", {7'd0, irq_chg}, 8'h00);
        wr(2'd3, 8'h00);
        check("R10 ext clr", {7'd0, irq_ext}, 8'h00);
        pin_in = 8'h50; settle();
        check("R9 fall ignored", {7'd0, irq_ext}, 8'h00);
        wr(2'd2, 8'h00);
        pin_in = 8'h51; settle();
        check("R9 rise ignored", {7'd0, irq_ext}, 8'h00);
        pin_in = 8'h50; settle();
        check("R9 fall", {7'd0, irq_ext}, 8'h01);
        wr(2'd3, 8'h02);
        check("R10 write keeps", {7'd0, irq_ext}, 8'h01);

        // random register and pin patterns: R1 R2 R3 R4
        for (int n = 0; n < 150; n++) begin
            dir_m  = 8'($urandom);
            lat_m  = 8'($urandom);
            pins_m = 8'($urandom);
            pull_m = 1'($urandom);
            wr(2'd1, dir_m);
            wr(2'd0, lat_m);
            wr(2'd2, {6'd0, 1'b1, pull_m});
            pin_in = pins_m; settle();
            rd(2'd0, "R2 rand", exp_read(dir_m, lat_m, pins_m));
            check("R1 rand oe", pin_oe, ~dir_m);
            check("R3 rand out", pin_out, lat_m);
            check("R4 rand pu", pin_pu, exp_pull(dir_m, pull_m));
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule